// File: doc/BRIEF.md
# Outbound Port Failure Policy Controller

This block sits beside the transmit queue of a serial-link port and decides, for each outbound packet, whether it goes onto the link, is thrown away, or waits. The decision is driven by a failure condition, which holds whenever the port's error-rate count has reached its failure threshold. A two-bit policy selects one of four reactions: keep retrying, discard only packets the link partner refuses, stall the queue with backpressure, or discard every packet. The retry and refused-only policies follow the live failure condition. The stall and discard-all policies stay in force through a sticky failure flag that only software can clear.

The controller tracks one outstanding packet. A request is granted (`tx_send_o`), dropped (`tx_drop_o`), or held by `stall_o`. A granted packet stays outstanding until the partner accepts it, or until a refusal makes the block discard it. The policy in force for a packet is captured when it is granted. A port lockout bit blocks the port in both directions. When lockout is clear, separate enables gate receive and transmit. On the inbound side the block flags every received packet that must be refused.

Top module: `port_fail_policy`

## Requirements
- R1: The failure condition holds when `err_cnt_i >= fail_thr_i`, equality included; the cycle after it holds, `fail_enc_o` is 1 and stays 1 after the count falls.
- R2: A `fail_clr_i` pulse clears `fail_enc_o` at the next edge, unless the failure condition holds in the same cycle, in which case the flag stays 1.
- R3: With policy 2'b00, requests are granted during failure, and a refusal (`rsp_valid_i` with `rsp_ok_i`=0) neither discards the packet nor ends it.
- R4: With policy 2'b01, a refusal of the outstanding packet while the failure condition holds pulses `rsp_discard_o` and ends the packet; a refusal while the count is below threshold does not discard.
- R5: With policy 2'b10 and the failure flag set (or failure present), `stall_o` is 1 and no request is granted or dropped, until the flag is cleared and the condition is gone.
- R6: With policy 2'b11 and the failure flag set (or failure present), every request is dropped (`tx_drop_o`=1, `tx_send_o`=0) until the flag is cleared.
- R7: `pkt_dropped_o` becomes 1 the edge after any drop or discard, stays 1, and is cleared only by `drop_clr_i`; a new drop in the same cycle wins.
- R8: The policy used to handle a packet's response is the one present when the packet was granted; later changes to `policy_i` do not affect it.
- R9: With `lockout_i`=1, `stall_o` is 1, nothing is granted or dropped, and `rx_refuse_o` follows every `rx_pkt_i` regardless of `in_en_i`.
- R10: With lockout clear, `out_en_i`=0 holds requests via `stall_o` (never dropped, even under policy 2'b11); `in_en_i`=0 makes `rx_refuse_o` follow `rx_pkt_i`, and with `in_en_i`=1 nothing is refused.
- R11: After reset both flags are 0, no packet is outstanding, and `port_type_o` reads 1.
- R12: While a packet is outstanding `stall_o` is 1; it clears the edge after an accepting response (`rsp_ok_i`=1) or a discard.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| policy_i | input | 2 | Failure policy: 00 retry, 01 drop refused, 10 stall, 11 drop all |
| lockout_i | input | 1 | Port blocked in both directions |
| in_en_i | input | 1 | Receive enable (used when lockout clear) |
| out_en_i | input | 1 | Transmit enable (used when lockout clear) |
| err_cnt_i | input | CNT_W | Current error-rate count |
| fail_thr_i | input | CNT_W | Failure threshold |
| fail_clr_i | input | 1 | Software clear of the failure flag |
| drop_clr_i | input | 1 | Write-one-to-clear of the dropped flag |
| pkt_req_i | input | 1 | Outbound packet waiting |
| rsp_valid_i | input | 1 | Response for the outstanding packet |
| rsp_ok_i | input | 1 | 1 accepted, 0 refused |
| rx_pkt_i | input | 1 | Inbound packet arriving |
| tx_send_o | output | 1 | Request granted onto the link |
| tx_drop_o | output | 1 | Request discarded |
| rsp_discard_o | output | 1 | Outstanding packet discarded after refusal |
| stall_o | output | 1 | Backpressure to the queue |
| fail_enc_o | output | 1 | Sticky failure flag |
| pkt_dropped_o | output | 1 | Sticky packet-dropped flag |
| rx_refuse_o | output | 1 | Inbound packet must be refused |
| port_type_o | output | 1 | Constant 1, serial port |

## Verification
The embedded assertions watch on every cycle that the failure flag rises after a failure and falls after a clean clear, that the dropped flag never decays by itself, that the captured policy stays frozen while a packet is outstanding, and that blocked or stalled ports never grant or drop. Only the directed scenarios show the interplay of the four policies with refusals, automatic recovery in the refused-only mode against software recovery in the others, and the effect of changing the policy mid-packet. Inbound refusal and the enable gating are also shown by scenarios.

// File: rtl/pfp_pkg.sv
package pfp_pkg;
  typedef enum logic [1:0] {
    POL_RETRY     = 2'b00,
    POL_DROP_NACK = 2'b01,
    POL_STALL     = 2'b10,
    POL_DROP_ALL  = 2'b11
  } fail_pol_e;
endpackage

// File: rtl/pfp_fail_track.sv
module pfp_fail_track #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] err_cnt_i,
  input  logic [CNT_W-1:0] fail_thr_i,
  input  logic             fail_clr_i,
  output logic             fail_now_o,
  output logic             fail_enc_o
);
  logic fail_enc_q, fail_enc_d, fail_enc_en;

  assign fail_now_o = (err_cnt_i >= fail_thr_i);

  always_comb begin
    fail_enc_en = fail_now_o | fail_clr_i;
    fail_enc_d  = fail_now_o;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           fail_enc_q <= 1'b0;
    else if (fail_enc_en) fail_enc_q <= fail_enc_d;
  end

  assign fail_enc_o = fail_enc_q;

  // R1
  fail_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (err_cnt_i >= fail_thr_i) |=> fail_enc_q);
  // R2
  fail_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fail_clr_i && (err_cnt_i < fail_thr_i)) |=> !fail_enc_q);
endmodule

// File: rtl/pfp_tx_ctrl.sv
module pfp_tx_ctrl
  import pfp_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] policy_i,
  input  logic       lockout_i,
  input  logic       out_en_i,
  input  logic       fail_now_i,
  input  logic       fail_enc_i,
  input  logic       drop_clr_i,
  input  logic       pkt_req_i,
  input  logic       rsp_valid_i,
  input  logic       rsp_ok_i,
  output logic       tx_send_o,
  output logic       tx_drop_o,
  output logic       rsp_discard_o,
  output logic       stall_o,
  output logic       pkt_dropped_o
);
  fail_pol_e pol_live, pol_q, pol_d;
  logic      in_pkt_q, in_pkt_d;
  logic      dropped_q, dropped_d, dropped_en;
  logic      fail_eff, pkt_end, blocked;

  assign pol_live = fail_pol_e'(policy_i);
  assign fail_eff = fail_now_i | fail_enc_i;
  assign blocked  = lockout_i | ~out_en_i;

  always_comb begin
    stall_o       = in_pkt_q | blocked | ((pol_live == POL_STALL) & fail_eff);
    tx_drop_o     = pkt_req_i & ~stall_o & (pol_live == POL_DROP_ALL) & fail_eff;
    tx_send_o     = pkt_req_i & ~stall_o & ~tx_drop_o;
    rsp_discard_o = in_pkt_q & rsp_valid_i & ~rsp_ok_i &
                    (pol_q == POL_DROP_NACK) & fail_now_i;
    pkt_end       = in_pkt_q & rsp_valid_i & (rsp_ok_i | rsp_discard_o);
  end

  always_comb begin
    in_pkt_d   = in_pkt_q;
    if (tx_send_o)    in_pkt_d = 1'b1;
    else if (pkt_end) in_pkt_d = 1'b0;
    pol_d      = tx_send_o ? pol_live : pol_q;
    dropped_en = tx_drop_o | rsp_discard_o | drop_clr_i;
    dropped_d  = tx_drop_o | rsp_discard_o;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_pkt_q  <= 1'b0;
      pol_q     <= POL_RETRY;
      dropped_q <= 1'b0;
    end else begin
      in_pkt_q <= in_pkt_d;
      if (tx_send_o)  pol_q     <= pol_d;
      if (dropped_en) dropped_q <= dropped_d;
    end
  end

  assign pkt_dropped_o = dropped_q;

  // R7
  dropped_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dropped_q && !drop_clr_i) |=> dropped_q);
  // R8
  pol_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_pkt_q && !pkt_end) |=> $stable(pol_q));
  // R9
  blocked_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    blocked |-> (!tx_send_o && !tx_drop_o));
  // R5
  stall_policy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((policy_i == 2'b10) && fail_enc_i) |-> (stall_o && !tx_send_o && !tx_drop_o));
  // R12
  one_pkt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_pkt_q |-> !tx_send_o);
endmodule

// File: rtl/pfp_rx_gate.sv
module pfp_rx_gate (
  input  logic lockout_i,
  input  logic in_en_i,
  input  logic rx_pkt_i,
  output logic rx_refuse_o
);
  logic rx_closed;
  assign rx_closed   = lockout_i | ~in_en_i;
  assign rx_refuse_o = rx_pkt_i & rx_closed;
endmodule

// File: rtl/port_fail_policy.sv
module port_fail_policy #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       policy_i,
  input  logic             lockout_i,
  input  logic             in_en_i,
  input  logic             out_en_i,
  input  logic [CNT_W-1:0] err_cnt_i,
  input  logic [CNT_W-1:0] fail_thr_i,
  input  logic             fail_clr_i,
  input  logic             drop_clr_i,
  input  logic             pkt_req_i,
  input  logic             rsp_valid_i,
  input  logic             rsp_ok_i,
  input  logic             rx_pkt_i,
  output logic             tx_send_o,
  output logic             tx_drop_o,
  output logic             rsp_discard_o,
  output logic             stall_o,
  output logic             fail_enc_o,
  output logic             pkt_dropped_o,
  output logic             rx_refuse_o,
  output logic             port_type_o
);
  logic fail_now;

  assign port_type_o = 1'b1;

  pfp_fail_track #(.CNT_W(CNT_W)) u_track (
    .clk        (clk),
    .rst_n      (rst_n),
    .err_cnt_i  (err_cnt_i),
    .fail_thr_i (fail_thr_i),
    .fail_clr_i (fail_clr_i),
    .fail_now_o (fail_now),
    .fail_enc_o (fail_enc_o)
  );

  pfp_tx_ctrl u_tx (
    .clk           (clk),
    .rst_n         (rst_n),
    .policy_i      (policy_i),
    .lockout_i     (lockout_i),
    .out_en_i      (out_en_i),
    .fail_now_i    (fail_now),
    .fail_enc_i    (fail_enc_o),
    .drop_clr_i    (drop_clr_i),
    .pkt_req_i     (pkt_req_i),
    .rsp_valid_i   (rsp_valid_i),
    .rsp_ok_i      (rsp_ok_i),
    .tx_send_o     (tx_send_o),
    .tx_drop_o     (tx_drop_o),
    .rsp_discard_o (rsp_discard_o),
    .stall_o       (stall_o),
    .pkt_dropped_o (pkt_dropped_o)
  );

  pfp_rx_gate u_rx (
    .lockout_i   (lockout_i),
    .in_en_i     (in_en_i),
    .rx_pkt_i    (rx_pkt_i),
    .rx_refuse_o (rx_refuse_o)
  );
endmodule

// File: tb/tb_port_fail_policy.sv
module tb_port_fail_policy;
  localparam int CLK_PERIOD = 10;
  localparam int CNT_W      = 8;

  logic clk = 1'b0;
  logic rst_n;
  logic [1:0] policy;
  logic lockout, in_en, out_en, fail_clr, drop_clr, pkt_req, rsp_valid, rsp_ok, rx_pkt;
  logic [CNT_W-1:0] err_cnt, fail_thr;
  logic tx_send, tx_drop, rsp_discard, stall, fail_enc, pkt_dropped, rx_refuse, port_type;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  port_fail_policy #(.CNT_W(CNT_W)) dut (
    .clk(clk), .rst_n(rst_n), .policy_i(policy), .lockout_i(lockout),
    .in_en_i(in_en), .out_en_i(out_en), .err_cnt_i(err_cnt), .fail_thr_i(fail_thr),
    .fail_clr_i(fail_clr), .drop_clr_i(drop_clr), .pkt_req_i(pkt_req),
    .rsp_valid_i(rsp_valid), .rsp_ok_i(rsp_ok), .rx_pkt_i(rx_pkt),
    .tx_send_o(tx_send), .tx_drop_o(tx_drop), .rsp_discard_o(rsp_discard),
    .stall_o(stall), .fail_enc_o(fail_enc), .pkt_dropped_o(pkt_dropped),
    .rx_refuse_o(rx_refuse), .port_type_o(port_type)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  // advance one edge, then settle inputs/outputs away from it
  task automatic tick();
    @(posedge clk);
    #1;
    fail_clr = 0; drop_clr = 0; rsp_valid = 0;
    #1;
  endtask

  task automatic settle();
    #1;
  endtask

  task automatic clean();
    pkt_req = 0; err_cnt = 0; policy = 2'b00;
    fail_clr = 1; drop_clr = 1;
    tick();
  endtask

  task automatic t_reset();
    chk("R11 fail_enc", fail_enc, 1'b0);
    chk("R11 pkt_dropped", pkt_dropped, 1'b0);
    chk("R11 port_type", port_type, 1'b1);
    chk("R11 stall", stall, 1'b0);
  endtask

  task automatic t_fail_flag();
    err_cnt = 9; tick();
    chk("R1 below threshold", fail_enc, 1'b0);
    err_cnt = 10; tick();
    chk("R1 equal threshold", fail_enc, 1'b1);
    err_cnt = 0; tick();
    chk("R1 sticky", fail_enc, 1'b1);
    fail_clr = 1; tick();
    chk("R2 clear", fail_enc, 1'b0);
    err_cnt = 10; fail_clr = 1; tick();
    chk("R2 detection wins", fail_enc, 1'b1);
    clean();
  endtask

  task automatic t_retry();
    policy = 2'b00; err_cnt = 12; pkt_req = 1; settle();
    chk("R3 send in failure", tx_send, 1'b1);
    chk("R3 no drop", tx_drop, 1'b0);
    tick(); pkt_req = 0; settle();
    chk("R12 outstanding stall", stall, 1'b1);
    rsp_valid = 1; rsp_ok = 0; settle();
    chk("R3 refusal no discard", rsp_discard, 1'b0);
    tick();
    chk("R3 packet still outstanding", stall, 1'b1);
    rsp_valid = 1; rsp_ok = 1; tick();
    chk("R12 accept ends packet", stall, 1'b0);
    clean();
  endtask

  task automatic t_drop_nack();
    policy = 2'b01; err_cnt = 12; pkt_req = 1; settle();
    chk("R4 send allowed", tx_send, 1'b1);
    tick(); pkt_req = 0;
    rsp_valid = 1; rsp_ok = 0; settle();
    chk("R4 discard on refusal", rsp_discard, 1'b1);
    tick();
    chk("R7 dropped set", pkt_dropped, 1'b1);
    chk("R12 discard ends packet", stall, 1'b0);
    pkt_req = 1; settle(); tick(); pkt_req = 0;
    err_cnt = 3;
    rsp_valid = 1; rsp_ok = 0; settle();
    chk("R4 recovered no discard", rsp_discard, 1'b0);
    tick(); tick();
    chk("R7 dropped sticky", pkt_dropped, 1'b1);
    rsp_valid = 1; rsp_ok = 1; tick();
    drop_clr = 1; tick();
    chk("R7 drop clear", pkt_dropped, 1'b0);
    clean();
  endtask

  task automatic t_stall();
    policy = 2'b10; err_cnt = 12; pkt_req = 1; settle();
    chk("R5 stall in failure", stall, 1'b1);
    chk("R5 no send", tx_send, 1'b0);
    chk("R5 no drop", tx_drop, 1'b0);
    tick(); err_cnt = 0; settle();
    chk("R5 stall held by flag", stall, 1'b1);
    pkt_req = 0; fail_clr = 1; tick();
    chk("R5 released after clear", stall, 1'b0);
    clean();
  endtask

  task automatic t_drop_all();
    policy = 2'b11; err_cnt = 12; pkt_req = 1; settle();
    chk("R6 drop", tx_drop, 1'b1);
    chk("R6 no send", tx_send, 1'b0);
    tick(); err_cnt = 0; settle();
    chk("R7 dropped after drop", pkt_dropped, 1'b1);
    chk("R6 drop held by flag", tx_drop, 1'b1);
    pkt_req = 0; fail_clr = 1; drop_clr = 1; tick();
    pkt_req = 1; settle();
    chk("R6 send after clear", tx_send, 1'b1);
    tick(); pkt_req = 0; rsp_valid = 1; rsp_ok = 1; tick();
    drop_clr = 1; tick();
    drop_clr = 1; pkt_req = 1; policy = 2'b11; err_cnt = 12; settle();
    tick();
    chk("R7 set wins over clear", pkt_dropped, 1'b1);
    clean();
  endtask

  task automatic t_policy_latch();
    policy = 2'b01; pkt_req = 1; settle(); tick(); pkt_req = 0;
    policy = 2'b00; err_cnt = 12; rsp_valid = 1; rsp_ok = 0; settle();
    chk("R8 captured drop-refused", rsp_discard, 1'b1);
    tick();
    clean();
    policy = 2'b00; pkt_req = 1; settle(); tick(); pkt_req = 0;
    policy = 2'b01; err_cnt = 12; rsp_valid = 1; rsp_ok = 0; settle();
    chk("R8 captured retry", rsp_discard, 1'b0);
    tick(); rsp_valid = 1; rsp_ok = 1; tick();
    clean();
  endtask

  task automatic t_lockout();
    lockout = 1; in_en = 1; pkt_req = 1; rx_pkt = 1; settle();
    chk("R9 stall", stall, 1'b1);
    chk("R9 no send", tx_send, 1'b0);
    chk("R9 refuse rx", rx_refuse, 1'b1);
    policy = 2'b11; err_cnt = 12; settle();
    chk("R9 no drop", tx_drop, 1'b0);
    lockout = 0; pkt_req = 0; rx_pkt = 0; tick();
    clean();
  endtask

  task automatic t_enables();
    out_en = 0; policy = 2'b11; err_cnt = 12; pkt_req = 1; settle();
    chk("R10 out disabled stall", stall, 1'b1);
    chk("R10 out disabled not dropped", tx_drop, 1'b0);
    pkt_req = 0; out_en = 1; tick();
    clean();
    rx_pkt = 1; in_en = 0; settle();
    chk("R10 in disabled refuse", rx_refuse, 1'b1);
    in_en = 1; settle();
    chk("R10 in enabled accept", rx_refuse, 1'b0);
    rx_pkt = 0;
  endtask

  initial begin
    rst_n = 0; policy = 0; lockout = 0; in_en = 1; out_en = 1;
    err_cnt = 0; fail_thr = 10; fail_clr = 0; drop_clr = 0;
    pkt_req = 0; rsp_valid = 0; rsp_ok = 0; rx_pkt = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    #1;
    t_reset();
    t_fail_flag();
    t_retry();
    t_drop_nack();
    t_stall();
    t_drop_all();
    t_policy_latch();
    t_lockout();
    t_enables();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 5000);
    errors++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule